// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block sits at the home node of a distributed shared-memory system with a small fixed number of nodes. For every memory block it owns, it holds a coherence state and a sharer bit vector with one bit per node. It also holds the backing data word. Cache-side controllers send it read misses, write misses and write-backs. It answers with data replies, invalidates to sharers, and fetch or fetch-invalidate requests to the current owner. When the owner returns its data, the block writes that data into memory before it completes the transition.

The block handles one miss at a time. A miss is accepted on the request port. From that cycle until its data reply leaves on the message port, the request port is held not-ready. A second request to the block in flight therefore waits until the first transition is complete. The directory entry changes only when the final reply is handed off. An exclusive entry has no separate owner field: the owner is the single set bit of its sharer vector.

The request and message ports follow valid/ready rules. A transfer takes place on a rising edge where both valid and ready are high. The controller holds msg_valid and every message field steady until msg_ready is seen. The requester may hold req_valid for as long as it likes. The owner-data port accepts a beat only while own_ready is high.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, every block is Uncached with an empty sharer set, and the memory word of block b holds the value b. req_ready is high, and msg_valid and own_ready are low.
- R2: A read miss (req_kind 0) to an Uncached block produces one data reply (msg_kind 0) to the requester, carrying the memory word. The block becomes Shared with the requester as its only sharer.
- R3: A write miss (req_kind 1) to an Uncached block produces one data reply to the requester. The block becomes Exclusive, owned by the requester.
- R4: A read miss to a Shared block produces one data reply carrying the memory word. The requester is added to the sharer set.
- R5: A write miss to a Shared block first sends an invalidate (msg_kind 1) to each sharer other than the requester, in ascending node order, and then sends the data reply. The block becomes Exclusive, owned by the requester.
- R6: A read miss to an Exclusive block sends a fetch (msg_kind 2) to the owner and waits for the owner's data. It writes that data into memory and replies with it. The block becomes Shared, with the old owner and the requester as sharers.
- R7: A write miss to an Exclusive block sends a fetch-invalidate (msg_kind 3) to the owner and writes the returned data into memory. It replies with that data. The requester becomes the sole owner and the block stays Exclusive.
- R8: A write-back (req_kind 2) from the owner of an Exclusive block writes req_data into memory and makes the block Uncached with an empty sharer set, with no message sent. A write-back from any other node, a write-back to a non-Exclusive block, and req_kind 3 all have no effect.
- R9: An owner-data beat whose own_node is not the expected owner is consumed and ignored. The controller keeps waiting for the owner.
- R10: While msg_valid is high and msg_ready is low, msg_kind, msg_node and msg_data stay stable. From acceptance of a miss until its data reply is taken, req_ready stays low.
- R11: The directory stays self-consistent across any sequence of requests. An Exclusive entry has exactly one sharer bit set, a Shared entry has at least one, and an Uncached entry has none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 ignored |
| req_node | input | NODE_W | Requesting node |
| req_blk | input | BLK_W | Block index |
| req_data | input | DATA_W | Write-back data |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Network accepts the message |
| msg_kind | output | 2 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch-invalidate |
| msg_node | output | NODE_W | Destination node |
| msg_blk | output | BLK_W | Block index of the message |
| msg_data | output | DATA_W | Reply data (zero for other kinds) |
| own_valid | input | 1 | Owner data beat present |
| own_ready | output | 1 | Controller is waiting for owner data |
| own_node | input | NODE_W | Node returning the data |
| own_data | input | DATA_W | Data returned by the owner |

## Verification
The assertions check several properties on every cycle:
- message fields stay stable under back-pressure;
- req_ready stays low while any message is pending;
- an invalidate is never addressed to the requester;
- a foreign owner beat leaves the controller still waiting;
- an accepted owner beat is followed at once by the data reply;
- the state and sharer-count invariant holds on every directory entry.

Other behaviours can only be shown by the bench's scenarios, because they depend on state built up over several transactions. These are the exact ordered message sequence for each state and miss combination, the data values that flow from owner through memory to later readers, and the silent dropping of stale write-backs.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    DIR_UNC = 2'd0,
    DIR_SHR = 2'd1,
    DIR_EXC = 2'd2
  } dir_state_e;

  localparam logic [1:0] RQ_READ  = 2'd0;
  localparam logic [1:0] RQ_WRITE = 2'd1;
  localparam logic [1:0] RQ_WBACK = 2'd2;

  localparam logic [1:0] MK_DATA  = 2'd0;
  localparam logic [1:0] MK_INV   = 2'd1;
  localparam logic [1:0] MK_FETCH = 2'd2;
  localparam logic [1:0] MK_FINV  = 2'd3;

  typedef enum logic [2:0] {
    C_IDLE  = 3'd0,
    C_INV   = 3'd1,
    C_FETCH = 3'd2,
    C_WAIT  = 3'd3,
    C_REPLY = 3'd4
  } ctl_e;
endpackage

// File: rtl/dir_sharer_pick.sv
module dir_sharer_pick #(
  parameter int NODES = 4,
  localparam int NODE_W = $clog2(NODES)
) (
  input  logic [NODES-1:0]  mask,
  output logic [NODE_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (mask[i]) idx = NODE_W'(i);
    end
  end
endmodule

// File: rtl/dir_entry_table.sv
module dir_entry_table
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 16,
  localparam int BLK_W = $clog2(BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] rd_idx,
  output dir_state_e       rd_state,
  output logic [NODES-1:0] rd_sh,
  input  logic             wr_en,
  input  logic [BLK_W-1:0] wr_idx,
  input  dir_state_e       wr_state,
  input  logic [NODES-1:0] wr_sh
);
  dir_state_e       st_q [BLOCKS];
  logic [NODES-1:0] sh_q [BLOCKS];

  assign rd_state = st_q[rd_idx];
  assign rd_sh    = sh_q[rd_idx];

  for (genvar g = 0; g < BLOCKS; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[g] <= DIR_UNC;
        sh_q[g] <= '0;
      end else if (wr_en && wr_idx == BLK_W'(g)) begin
        st_q[g] <= wr_state;
        sh_q[g] <= wr_sh;
      end
    end

    p_excl_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
      st_q[g] == DIR_EXC |-> $countones(sh_q[g]) == 1);
    p_unc_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
      st_q[g] == DIR_UNC |-> sh_q[g] == '0);
    p_shr_nonempty_r11: assert property (@(posedge clk) disable iff (!rst_n)
      st_q[g] == DIR_SHR |-> sh_q[g] != '0);
  end
endmodule

// File: rtl/dir_data_store.sv
module dir_data_store #(
  parameter int BLOCKS = 16,
  parameter int DATA_W = 32,
  localparam int BLK_W = $clog2(BLOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLK_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [BLK_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] mem_q [BLOCKS];

  assign rd_data = mem_q[rd_idx];

  for (genvar g = 0; g < BLOCKS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[g] <= DATA_W'(g);
      else if (wr_en && wr_idx == BLK_W'(g)) mem_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 16,
  parameter int DATA_W = 32,
  localparam int NODE_W = $clog2(NODES),
  localparam int BLK_W  = $clog2(BLOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [NODE_W-1:0] req_node,
  input  logic [BLK_W-1:0]  req_blk,
  input  logic [DATA_W-1:0] req_data,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [1:0]        msg_kind,
  output logic [NODE_W-1:0] msg_node,
  output logic [BLK_W-1:0]  msg_blk,
  output logic [DATA_W-1:0] msg_data,
  input  logic              own_valid,
  output logic              own_ready,
  input  logic [NODE_W-1:0] own_node,
  input  logic [DATA_W-1:0] own_data
);
  function automatic logic [NODES-1:0] node_bit(input logic [NODE_W-1:0] n);
    logic [NODES-1:0] v;
    v = '0;
    v[n] = 1'b1;
    return v;
  endfunction

  ctl_e              ctl_q;
  logic              wr_q;
  logic [NODE_W-1:0] node_q;
  logic [NODE_W-1:0] owner_q;
  logic [BLK_W-1:0]  blk_q;
  logic [NODES-1:0]  pend_q;

  logic              idle;
  logic              accept;
  logic              wb_hit;
  logic              own_take;
  logic [BLK_W-1:0]  cur_blk;
  dir_state_e        ent_st;
  logic [NODES-1:0]  ent_sh;
  logic [NODES-1:0]  req_bit;
  logic [NODES-1:0]  others;
  logic [NODE_W-1:0] ent_owner;
  logic [NODE_W-1:0] inv_idx;
  logic [NODES-1:0]  pend_left;
  logic [DATA_W-1:0] mem_rd;

  logic              tbl_we;
  dir_state_e        tbl_wst;
  logic [NODES-1:0]  tbl_wsh;
  logic              mem_we;
  logic [DATA_W-1:0] mem_wd;

  assign idle      = (ctl_q == C_IDLE);
  assign req_ready = idle;
  assign own_ready = (ctl_q == C_WAIT);
  assign accept    = req_valid && idle;
  assign cur_blk   = idle ? req_blk : blk_q;
  assign req_bit   = node_bit(req_node);
  assign others    = ent_sh & ~req_bit;
  assign wb_hit    = accept && req_kind == RQ_WBACK && ent_st == DIR_EXC && ent_sh[req_node];
  assign own_take  = own_valid && own_ready && own_node == owner_q;
  assign pend_left = pend_q & ~node_bit(inv_idx);

  dir_entry_table #(.NODES(NODES), .BLOCKS(BLOCKS)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(cur_blk), .rd_state(ent_st), .rd_sh(ent_sh),
    .wr_en(tbl_we), .wr_idx(cur_blk), .wr_state(tbl_wst), .wr_sh(tbl_wsh)
  );

  dir_data_store #(.BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(cur_blk), .rd_data(mem_rd),
    .wr_en(mem_we), .wr_idx(cur_blk), .wr_data(mem_wd)
  );

  dir_sharer_pick #(.NODES(NODES)) u_pick_owner (.mask(ent_sh), .idx(ent_owner));
  dir_sharer_pick #(.NODES(NODES)) u_pick_inv   (.mask(pend_q), .idx(inv_idx));

  // Directory and memory write ports
  always_comb begin
    tbl_we  = 1'b0;
    tbl_wst = DIR_UNC;
    tbl_wsh = '0;
    if (wb_hit) begin
      tbl_we = 1'b1;
    end else if (ctl_q == C_REPLY && msg_ready) begin
      tbl_we = 1'b1;
      if (wr_q) begin
        tbl_wst = DIR_EXC;
        tbl_wsh = node_bit(node_q);
      end else begin
        tbl_wst = DIR_SHR;
        tbl_wsh = ent_sh | node_bit(node_q);
      end
    end
    mem_we = wb_hit || own_take;
    mem_wd = idle ? req_data : own_data;
  end

  // Sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= C_IDLE;
      wr_q    <= 1'b0;
      node_q  <= '0;
      owner_q <= '0;
      blk_q   <= '0;
      pend_q  <= '0;
    end else begin
      case (ctl_q)
        C_IDLE: if (accept) begin
          node_q  <= req_node;
          blk_q   <= req_blk;
          wr_q    <= (req_kind == RQ_WRITE);
          owner_q <= ent_owner;
          pend_q  <= others;
          if (req_kind == RQ_READ || req_kind == RQ_WRITE) begin
            if (ent_st == DIR_EXC) ctl_q <= C_FETCH;
            else if (req_kind == RQ_WRITE && ent_st == DIR_SHR && others != '0) ctl_q <= C_INV;
            else ctl_q <= C_REPLY;
          end
        end
        C_INV: if (msg_ready) begin
          pend_q <= pend_left;
          if (pend_left == '0) ctl_q <= C_REPLY;
        end
        C_FETCH: if (msg_ready) ctl_q <= C_WAIT;
        C_WAIT:  if (own_take) ctl_q <= C_REPLY;
        C_REPLY: if (msg_ready) ctl_q <= C_IDLE;
        default: ctl_q <= C_IDLE;
      endcase
    end
  end

  // Outgoing message
  always_comb begin
    msg_valid = 1'b0;
    msg_kind  = MK_DATA;
    msg_node  = node_q;
    msg_data  = '0;
    msg_blk   = blk_q;
    case (ctl_q)
      C_INV: begin
        msg_valid = 1'b1;
        msg_kind  = MK_INV;
        msg_node  = inv_idx;
      end
      C_FETCH: begin
        msg_valid = 1'b1;
        msg_kind  = wr_q ? MK_FINV : MK_FETCH;
        msg_node  = owner_q;
      end
      C_REPLY: begin
        msg_valid = 1'b1;
        msg_data  = mem_rd;
      end
      default: ;
    endcase
  end

  p_msg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_kind) && $stable(msg_node) && $stable(msg_data));
  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !req_ready);
  p_inv_skip_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind == MK_INV |-> msg_node != node_q);
  p_reply_after_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    own_take |=> msg_valid && msg_kind == MK_DATA);
  p_foreign_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    own_valid && own_ready && own_node != owner_q |=> own_ready);
endmodule

// File: tb/test_dir_home_ctrl.sv
module test_dir_home_ctrl;
  localparam int NODES = 4;
  localparam int BLOCKS = 16;
  localparam int DATA_W = 32;
  localparam int NW = $clog2(NODES);
  localparam int BW = $clog2(BLOCKS);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, msg_ready = 0, own_valid = 0;
  logic req_ready, msg_valid, own_ready;
  logic [1:0] req_kind = 0, msg_kind;
  logic [NW-1:0] req_node = 0, msg_node, own_node = 0;
  logic [BW-1:0] req_blk = 0, msg_blk;
  logic [DATA_W-1:0] req_data = 0, msg_data, own_data = 0;

  int checks = 0, errors = 0;
  bit finished = 0;

  int m_st [BLOCKS];  // 0 U, 1 S, 2 E
  logic [NODES-1:0] m_sh [BLOCKS];
  logic [DATA_W-1:0] m_mem [BLOCKS];

  always #2 clk = ~clk;

  dir_home_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) i_dir_home_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_node(req_node), .req_blk(req_blk), .req_data(req_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
    .msg_node(msg_node), .msg_blk(msg_blk), .msg_data(msg_data),
    .own_valid(own_valid), .own_ready(own_ready), .own_node(own_node), .own_data(own_data)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int low_owner(input logic [NODES-1:0] m);
    for (int i = NODES - 1; i >= 0; i--) if (m[i]) low_owner = i;
    if (m == '0) low_owner = 0;
  endfunction

  task automatic run_txn(input int kind, input int node, input int blk,
                         input logic [DATA_W-1:0] wdata, input logic [DATA_W-1:0] odata,
                         input bit bad_first, input string tag);
    int ek [8]; int en [8]; logic [DATA_W-1:0] ed [8];
    int n_exp = 0, got = 0, cyc = 0, owner;
    bit done = 0, stall_bad = 0, hold_bad = 0, fetch_seen = 0, own_done = 0, hold_pend = 0;
    bit bad_pend = bad_first;
    logic [1:0] hk; logic [NW-1:0] hn; logic [DATA_W-1:0] hd;
    owner = low_owner(m_sh[blk]);
    if (kind < 2) begin
      if (m_st[blk] == 2) begin
        ek[0] = kind ? 3 : 2; en[0] = owner; ed[0] = 0; n_exp = 1;
        ek[1] = 0; en[1] = node; ed[1] = odata; n_exp = 2;
      end else begin
        if (kind == 1 && m_st[blk] == 1)
          for (int n = 0; n < NODES; n++)
            if (m_sh[blk][n] && n != node) begin
              ek[n_exp] = 1; en[n_exp] = n; ed[n_exp] = 0; n_exp++;
            end
        ek[n_exp] = 0; en[n_exp] = node; ed[n_exp] = m_mem[blk]; n_exp++;
      end
    end
    @(negedge clk);
    req_valid = 1; req_kind = 2'(kind); req_node = NW'(node); req_blk = BW'(blk); req_data = wdata;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    if (kind >= 2) begin
      for (int i = 0; i < 3; i++) begin
        if (msg_valid || !req_ready) stall_bad = 1;
        @(negedge clk);
      end
      chk(!stall_bad, tag, "write-back/ignored kind sent a message or stalled", stall_bad, 0);
      if (kind == 2 && m_st[blk] == 2 && m_sh[blk][node]) begin
        m_mem[blk] = wdata; m_st[blk] = 0; m_sh[blk] = '0;
      end
      return;
    end
    while (!done && cyc < 2000) begin
      if (req_ready) stall_bad = 1;
      if (hold_pend) begin
        if (!msg_valid || msg_kind != hk || msg_node != hn || msg_data != hd) hold_bad = 1;
        hold_pend = 0;
      end
      if (fetch_seen && !own_done) begin
        own_valid = 1;
        own_node = NW'(bad_pend ? (owner + 1) % NODES : owner);
        own_data = bad_pend ? ~odata : odata;
        if (own_ready) begin
          if (bad_pend) bad_pend = 0; else own_done = 1;
        end
      end else own_valid = 0;
      msg_ready = ($urandom % 4) != 0;
      if (msg_valid && msg_ready) begin
        if (got < n_exp) begin
          chk(msg_kind == 2'(ek[got]), tag, "message kind", msg_kind, ek[got]);
          chk(msg_node == NW'(en[got]), tag, "message node", msg_node, en[got]);
          if (ek[got] == 0) chk(msg_data == ed[got], tag, "reply data", msg_data, ed[got]);
        end else chk(0, tag, "extra message", msg_kind, 0);
        got++;
        if (msg_kind == 2'd0) done = 1;
        if (msg_kind[1]) fetch_seen = 1;
      end else if (msg_valid) begin
        hold_pend = 1; hk = msg_kind; hn = msg_node; hd = msg_data;
      end
      @(negedge clk);
      cyc++;
    end
    own_valid = 0; msg_ready = 0;
    chk(done, tag, "data reply seen", done, 1);
    chk(got == n_exp, tag, "message count", got, n_exp);
    chk(!stall_bad, "R10", "req_ready high mid-transaction", stall_bad, 0);
    chk(!hold_bad, "R10", "message changed under back-pressure", hold_bad, 0);
    chk(req_ready, "R10", "req_ready after reply", req_ready, 1);
    if (m_st[blk] == 2) m_mem[blk] = odata;
    if (kind == 0) begin m_sh[blk] = m_sh[blk] | (NODES'(1) << node); m_st[blk] = 1; end
    else begin m_sh[blk] = NODES'(1) << node; m_st[blk] = 2; end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R10: watchdog expired, actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int b = 0; b < BLOCKS; b++) begin m_st[b] = 0; m_sh[b] = '0; m_mem[b] = b; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1", "req_ready after reset", req_ready, 1);
    chk(msg_valid == 0, "R1", "msg_valid after reset", msg_valid, 0);
    chk(own_ready == 0, "R1", "own_ready after reset", own_ready, 0);
    run_txn(0, 2, 7, 0, 0, 0, "R1");           // reset word of block 7 is 7
    run_txn(0, 0, 1, 0, 0, 0, "R2");
    run_txn(0, 2, 1, 0, 0, 0, "R4");
    run_txn(1, 1, 1, 0, 0, 0, "R5");            // inv 0, inv 2, reply
    run_txn(0, 3, 1, 0, 32'hA5A5_0001, 1, "R9"); // foreign beat first
    run_txn(0, 0, 1, 0, 0, 0, "R6");            // shared, reply new data
    run_txn(1, 2, 1, 0, 0, 0, "R5");            // inv 0,1,3
    run_txn(1, 0, 1, 0, 32'hC3C3_0002, 0, "R7");
    run_txn(2, 1, 1, 32'hDEAD_0003, 0, 0, "R8"); // non-owner, ignored
    run_txn(3, 0, 1, 32'hDEAD_0004, 0, 0, "R8"); // reserved kind, ignored
    run_txn(2, 0, 1, 32'hBEEF_0005, 0, 0, "R8"); // owner write-back
    run_txn(0, 3, 1, 0, 0, 0, "R8");            // reads write-back data
    run_txn(1, 3, 5, 0, 0, 0, "R3");
    run_txn(0, 1, 5, 0, 32'h1234_0006, 0, "R6");
    for (int t = 0; t < 300; t++) begin
      int r = $urandom % 100;
      int k = (r < 40) ? 0 : (r < 75) ? 1 : (r < 95) ? 2 : 3;
      int b = ($urandom % 8 == 0) ? $urandom % BLOCKS : $urandom % 4;
      int n = $urandom % NODES;
      if (k == 2 && m_st[b] == 2 && ($urandom % 4) != 0) n = low_owner(m_sh[b]);
      run_txn(k, n, b, $urandom, $urandom, ($urandom % 4) == 0, "R11");
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule